// File: doc/BRIEF.md
# ADC Channel Sweep Sequencer with Transfer Status

This block runs an external analog-to-digital converter over a range of input channels again and again, with no software involvement per sample. Each pass starts at channel 0 and ends at a programmed last channel. For every channel it raises a one-cycle start request with the channel number and waits for the converter's done pulse. It then writes the 16-bit result to memory as two byte writes before it starts the next channel.

A status word gives software two things. It shows the channel that is in progress. It also holds three interrupt-request flags: one raised by this sequencer when a pass completes, and two raised by event inputs from neighbouring transfer channels. Reading the status word clears all three flags at once.

Clearing the enable does not abort anything. The conversion in progress and its transfer finish first, and then the sequencer parks in idle.

Top module: `adc_sweep_dma`

## Requirements
- R1: The 4-bit `last_ch` code k, for k from 0 to 11, makes each pass convert channels 0 through k inclusive.
- R2: Codes 12 to 15 are invalid. They never start a pass from idle. If `last_ch` holds one of them when a pass ends, the sequencer returns to idle instead of starting the next pass.
- R3: A pass starts at channel 0 and goes up by exactly one channel per conversion. `conv_start` is high for a single cycle, with `conv_ch` holding the channel.
- R4: The result of each conversion is fully written to memory before the next `conv_start` is raised.
- R5: The result of channel c goes to two byte addresses. The low byte goes to `base_addr + 2c` and the high byte to `base_addr + 2c + 1`, low byte first. Each byte completes in a cycle in which `mem_we` and `mem_ack` are both high.
- R6: Status bits 7:4 show the channel being converted and read 0 while idle. Bit 3 always reads 0.
- R7: Status bit 2 sets once the high byte of the pass's last channel is accepted. Bits 1 and 0 set on a high cycle of `irq_ev1` and `irq_ev0` respectively.
- R8: Status bits 2:0 are all cleared in the cycle `stat_rd` is high. A set event in that same cycle wins over the clear, for its own bit only.
- R9: While `en` stays high and the code stays valid, a new pass begins at channel 0 right after the previous pass's last write.
- R10: When `en` falls, the current conversion and its transfer still complete. No further conversion starts, and the channel field returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Keep sweeping while high |
| last_ch | input | 4 | Last channel of a pass (0..11 valid) |
| base_addr | input | 8 | Byte address of channel 0's result |
| conv_start | output | 1 | One-cycle conversion request |
| conv_ch | output | 4 | Channel to convert |
| conv_done | input | 1 | Converter result valid pulse |
| conv_data | input | 16 | Converter result |
| mem_we | output | 1 | Byte write request |
| mem_addr | output | 8 | Byte write address |
| mem_wdata | output | 8 | Byte write data |
| mem_ack | input | 1 | Byte write accepted |
| irq_ev1 | input | 1 | Neighbour channel 1 interrupt event |
| irq_ev0 | input | 1 | Neighbour channel 0 interrupt event |
| stat_rd | input | 1 | Status read strobe (clears flags) |
| stat_q | output | 8 | Status word: channel, reserved 0, three flags |

## Verification
The bench programs the smallest and largest valid codes and reserved codes, and it changes the code to a reserved value in the middle of a pass. A design that decoded reserved codes would keep converting, and one that sampled the code only once would wrap instead of stopping. It drops the enable while a conversion is in flight and checks that the bytes of that channel still land and that no later channel starts. A design that aborted would lose bytes, and one that ignored the drop would keep sweeping. It also lines up a status read with a flag event in the same cycle. If the clear had priority, that event would be lost. If the read cleared nothing, stale flags would remain.

// File: rtl/adc_sweep_pkg.sv
package adc_sweep_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_KICK,
    SEQ_CONV,
    SEQ_MOVE
  } seq_state_t;

  // A channel-count code is usable only up to the highest wired channel.
  function automatic logic code_ok(input int code, input int max_last);
    return (code >= 0) && (code <= max_last);
  endfunction

  // Byte address of one beat of one channel's result.
  function automatic int beat_addr(input int base, input int ch,
                                   input int nbytes, input int beat);
    return base + ch * nbytes + beat;
  endfunction

endpackage

// File: rtl/adc_sweep_ctrl.sv
module adc_sweep_ctrl
  import adc_sweep_pkg::*;
#(
  parameter int CW       = 4,
  parameter int MAX_LAST = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] last_ch,
  input  logic          conv_done,
  input  logic          xfer_done,
  output logic          conv_start,
  output logic [CW-1:0] cur_ch,
  output logic [CW-1:0] last_q,
  output logic          xfer_go,
  output logic          sweep_done,
  output logic          seq_idle
);

  seq_state_t state;
  logic       code_valid;
  logic       at_last;

  assign code_valid = code_ok(int'(last_ch), MAX_LAST);
  assign at_last    = (cur_ch == last_q);
  assign conv_start = (state == SEQ_KICK);
  assign xfer_go    = (state == SEQ_CONV) && conv_done;
  assign sweep_done = (state == SEQ_MOVE) && xfer_done && at_last;
  assign seq_idle   = (state == SEQ_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SEQ_IDLE;
      cur_ch <= '0;
      last_q <= '0;
    end else begin
      case (state)
        SEQ_IDLE: begin
          if (en && code_valid) begin
            last_q <= last_ch;
            cur_ch <= '0;
            state  <= SEQ_KICK;
          end
        end
        SEQ_KICK: state <= SEQ_CONV;
        SEQ_CONV: begin
          if (conv_done) state <= SEQ_MOVE;
        end
        SEQ_MOVE: begin
          if (xfer_done) begin
            if (!en) begin
              cur_ch <= '0;
              state  <= SEQ_IDLE;
            end else if (at_last) begin
              cur_ch <= '0;
              if (code_valid) begin
                last_q <= last_ch;
                state  <= SEQ_KICK;
              end else begin
                state <= SEQ_IDLE;
              end
            end else begin
              cur_ch <= cur_ch + CW'(1);
              state  <= SEQ_KICK;
            end
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/adc_sweep_mover.sv
module adc_sweep_mover
  import adc_sweep_pkg::*;
#(
  parameter int AW = 8,
  parameter int CW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [CW-1:0] ch,
  input  logic [AW-1:0] base_addr,
  input  logic [DW-1:0] conv_data,
  input  logic          mem_ack,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          done
);

  localparam int NB = DW / 8;
  localparam int BW = (NB > 1) ? $clog2(NB) : 1;

  logic          busy;
  logic [BW-1:0] beat;
  logic [DW-1:0] data_q;
  logic [AW-1:0] addr0_q;
  logic          last_beat;

  assign last_beat = (int'(beat) == NB - 1);
  assign mem_we    = busy;
  assign mem_addr  = addr0_q + AW'(beat);
  assign mem_wdata = data_q[int'(beat)*8 +: 8];
  assign done      = busy && mem_ack && last_beat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      beat    <= '0;
      data_q  <= '0;
      addr0_q <= '0;
    end else if (go) begin
      busy    <= 1'b1;
      beat    <= '0;
      data_q  <= conv_data;
      addr0_q <= AW'(beat_addr(int'(base_addr), int'(ch), NB, 0));
    end else if (busy && mem_ack) begin
      if (last_beat) busy <= 1'b0;
      else           beat <= beat + BW'(1);
    end
  end

endmodule

// File: rtl/adc_sweep_stat.sv
module adc_sweep_stat #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cur_ch,
  input  logic          set_adc,
  input  logic          set_1,
  input  logic          set_0,
  input  logic          rd,
  output logic [CW+3:0] stat_q
);

  localparam int NF = 3;

  logic [NF-1:0] set_vec;
  logic [NF-1:0] flags;

  assign set_vec = {set_adc, set_1, set_0};

  for (genvar i = 0; i < NF; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flags[i] <= 1'b0;
      else if (set_vec[i]) flags[i] <= 1'b1;
      else if (rd)         flags[i] <= 1'b0;
    end
  end

  assign stat_q = {cur_ch, 1'b0, flags};

endmodule

// File: rtl/adc_sweep_dma.sv
module adc_sweep_dma #(
  parameter int AW       = 8,
  parameter int CW       = 4,
  parameter int DW       = 16,
  parameter int MAX_LAST = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] last_ch,
  input  logic [AW-1:0] base_addr,
  output logic          conv_start,
  output logic [CW-1:0] conv_ch,
  input  logic          conv_done,
  input  logic [DW-1:0] conv_data,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic          mem_ack,
  input  logic          irq_ev1,
  input  logic          irq_ev0,
  input  logic          stat_rd,
  output logic [CW+3:0] stat_q
);

  logic [CW-1:0] cur_ch;
  logic [CW-1:0] sweep_last;
  logic          xfer_go;
  logic          xfer_done;
  logic          sweep_done;
  logic          seq_idle;

  adc_sweep_ctrl #(.CW(CW), .MAX_LAST(MAX_LAST)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .en(en), .last_ch(last_ch),
    .conv_done(conv_done), .xfer_done(xfer_done),
    .conv_start(conv_start), .cur_ch(cur_ch), .last_q(sweep_last),
    .xfer_go(xfer_go), .sweep_done(sweep_done), .seq_idle(seq_idle)
  );

  adc_sweep_mover #(.AW(AW), .CW(CW), .DW(DW)) u_mover (
    .clk(clk), .rst_n(rst_n), .go(xfer_go), .ch(cur_ch),
    .base_addr(base_addr), .conv_data(conv_data), .mem_ack(mem_ack),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .done(xfer_done)
  );

  adc_sweep_stat #(.CW(CW)) u_stat (
    .clk(clk), .rst_n(rst_n), .cur_ch(cur_ch), .set_adc(sweep_done),
    .set_1(irq_ev1), .set_0(irq_ev0), .rd(stat_rd), .stat_q(stat_q)
  );

  assign conv_ch = cur_ch;

endmodule

// File: rtl/adc_sweep_chk.sv
module adc_sweep_chk #(
  parameter int CW       = 4,
  parameter int MAX_LAST = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          conv_start,
  input logic [CW-1:0] conv_ch,
  input logic [CW-1:0] sweep_last,
  input logic          mem_we,
  input logic          sweep_done,
  input logic          seq_idle,
  input logic          stat_rd,
  input logic          irq_ev1,
  input logic          irq_ev0,
  input logic [CW+3:0] stat_q
);

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start); // R3
  AST_CH_WITHIN_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (conv_ch <= sweep_last)); // R1
  AST_LAST_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (int'(sweep_last) <= MAX_LAST)); // R2
  AST_NO_START_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !conv_start); // R4
  AST_RSVD_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[3] == 1'b0); // R6
  AST_IDLE_CH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    seq_idle |-> (stat_q[CW+3:4] == '0)); // R10
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_done |=> stat_q[2]); // R7
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !sweep_done && !irq_ev1 && !irq_ev0) |=> (stat_q[2:0] == 3'b000)); // R8

endmodule

bind adc_sweep_dma adc_sweep_chk #(.CW(CW), .MAX_LAST(MAX_LAST)) u_chk (
  .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_ch(conv_ch),
  .sweep_last(sweep_last), .mem_we(mem_we), .sweep_done(sweep_done),
  .seq_idle(seq_idle), .stat_rd(stat_rd), .irq_ev1(irq_ev1),
  .irq_ev0(irq_ev0), .stat_q(stat_q)
);

// File: tb/sim_adc_sweep_dma.sv
module sim_adc_sweep_dma;

  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [3:0]  last_ch = 4'd0;
  logic [7:0]  base_addr = 8'h00;
  logic        conv_start;
  logic [3:0]  conv_ch;
  logic        conv_done = 1'b0;
  logic [15:0] conv_data = 16'h0;
  logic        mem_we;
  logic [7:0]  mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_ack = 1'b0;
  logic        irq_ev1 = 1'b0;
  logic        irq_ev0 = 1'b0;
  logic        stat_rd = 1'b0;
  logic [7:0]  stat_q;

  int errors = 0;
  int checks = 0;
  int log_ch [0:255];
  int log_n = 0;
  int wr_bytes = 0;
  int busy_cnt = 0;
  int pend_ch = 0;
  logic [7:0] mem [0:255];

  always #(PERIOD/2) clk = ~clk;

  adc_sweep_dma u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .last_ch(last_ch), .base_addr(base_addr),
    .conv_start(conv_start), .conv_ch(conv_ch), .conv_done(conv_done),
    .conv_data(conv_data), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .irq_ev1(irq_ev1),
    .irq_ev0(irq_ev0), .stat_rd(stat_rd), .stat_q(stat_q)
  );

  function automatic logic [15:0] pat(input int ch);
    return {4'hC, 4'(ch), 4'h3, ~4'(ch)};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Converter model: result three cycles after a start request.
  always @(negedge clk) begin
    if (conv_done) conv_done = 1'b0;
    if (busy_cnt > 0) begin
      busy_cnt--;
      if (busy_cnt == 0) begin
        conv_done = 1'b1;
        conv_data = pat(pend_ch);
      end
    end
    if (conv_start && rst_n) begin
      chk(wr_bytes == 2 * log_n, "R4", "bytes written before start", wr_bytes, 2 * log_n);
      chk(stat_q[7:4] == conv_ch, "R6", "status channel field", int'(stat_q[7:4]), int'(conv_ch));
      log_ch[log_n & 255] = int'(conv_ch);
      log_n++;
      pend_ch = int'(conv_ch);
      busy_cnt = 3;
    end
  end

  // Memory model: accepts one byte per cycle.
  always @(negedge clk) begin
    if (mem_we && rst_n) begin
      mem[mem_addr] = mem_wdata;
      mem_ack = 1'b1;
      wr_bytes++;
    end else begin
      mem_ack = 1'b0;
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 8'hEE;
  endtask

  task automatic read_status();
    stat_rd = 1'b1;
    tick();
    stat_rd = 1'b0;
  endtask

  task automatic wait_log(input int target);
    for (int i = 0; i < 3000 && log_n < target; i++) tick();
  endtask

  task automatic wait_adc_flag();
    for (int i = 0; i < 3000 && !stat_q[2]; i++) tick();
  endtask

  task automatic check_mem(input int base, input int ch, input string req);
    logic [15:0] exp = pat(ch);
    chk(mem[(base + 2*ch) & 255] == exp[7:0], req, "low byte", int'(mem[(base + 2*ch) & 255]), int'(exp[7:0]));
    chk(mem[(base + 2*ch + 1) & 255] == exp[15:8], req, "high byte", int'(mem[(base + 2*ch + 1) & 255]), int'(exp[15:8]));
  endtask

  task automatic t_reset();
    chk(stat_q == 8'h00, "R6", "status after reset", int'(stat_q), 0);
    chk(!mem_we && !conv_start, "R3", "quiet after reset", int'({mem_we, conv_start}), 0);
  endtask

  task automatic t_sweep(input int k, input int base);
    int s;
    clear_mem();
    base_addr = 8'(base);
    last_ch = 4'(k);
    s = log_n;
    en = 1'b1;
    wait_adc_flag();
    en = 1'b0;
    repeat (40) tick();
    chk(log_n - s >= k + 1, "R1", "conversions in pass", log_n - s, k + 1);
    for (int i = 0; i <= k; i++)
      chk(log_ch[(s + i) & 255] == i, "R3", "channel order", log_ch[(s + i) & 255], i);
    for (int i = 0; i <= k; i++) check_mem(base, i, "R5");
    chk(mem[(base + 2*k + 2) & 255] == 8'hEE, "R1", "no write past last", int'(mem[(base + 2*k + 2) & 255]), 8'hEE);
    chk(stat_q[2] == 1'b1, "R7", "pass flag set", int'(stat_q[2]), 1);
    read_status();
    chk(stat_q[2:0] == 3'b000, "R8", "flags after read", int'(stat_q[2:0]), 0);
  endtask

  task automatic t_reserved();
    int s = log_n;
    last_ch = 4'd12;
    en = 1'b1;
    repeat (30) tick();
    chk(log_n == s, "R2", "code 12 starts nothing", log_n - s, 0);
    last_ch = 4'd15;
    repeat (30) tick();
    chk(log_n == s, "R2", "code 15 starts nothing", log_n - s, 0);
    chk(stat_q[7:4] == 4'd0, "R6", "idle channel field", int'(stat_q[7:4]), 0);
    en = 1'b0;
    tick();
  endtask

  task automatic t_reserved_wrap();
    int s = log_n;
    last_ch = 4'd2;
    en = 1'b1;
    wait_log(s + 1);
    last_ch = 4'd13;
    repeat (80) tick();
    chk(log_n - s == 3, "R2", "stop at wrap on bad code", log_n - s, 3);
    chk(stat_q[2] == 1'b1, "R7", "flag after final pass", int'(stat_q[2]), 1);
    en = 1'b0;
    read_status();
  endtask

  task automatic t_wrap();
    int s = log_n;
    clear_mem();
    base_addr = 8'h80;
    last_ch = 4'd1;
    en = 1'b1;
    wait_log(s + 5);
    en = 1'b0;
    repeat (40) tick();
    for (int i = 0; i < 5; i++)
      chk(log_ch[(s + i) & 255] == (i % 2), "R9", "restart sequence", log_ch[(s + i) & 255], i % 2);
    read_status();
  endtask

  task automatic t_stop();
    int s = log_n;
    clear_mem();
    base_addr = 8'h20;
    last_ch = 4'd5;
    en = 1'b1;
    wait_log(s + 3);
    en = 1'b0;
    repeat (40) tick();
    chk(log_n - s == 3, "R10", "no start after disable", log_n - s, 3);
    check_mem(32'h20, 2, "R10");
    chk(stat_q[7:4] == 4'd0, "R10", "channel field back to 0", int'(stat_q[7:4]), 0);
    chk(stat_q[2] == 1'b0, "R10", "no pass flag on early stop", int'(stat_q[2]), 0);
  endtask

  task automatic t_flags();
    read_status();
    irq_ev1 = 1'b1; tick(); irq_ev1 = 1'b0;
    chk(stat_q[2:0] == 3'b010, "R7", "event 1 flag", int'(stat_q[2:0]), 2);
    irq_ev0 = 1'b1; tick(); irq_ev0 = 1'b0;
    chk(stat_q[2:0] == 3'b011, "R7", "event 0 flag", int'(stat_q[2:0]), 3);
    read_status();
    chk(stat_q[2:0] == 3'b000, "R8", "read clears both", int'(stat_q[2:0]), 0);
    irq_ev1 = 1'b1; tick(); irq_ev1 = 1'b0;
    stat_rd = 1'b1; irq_ev0 = 1'b1; tick();
    stat_rd = 1'b0; irq_ev0 = 1'b0;
    chk(stat_q[2:0] == 3'b001, "R8", "set wins same-cycle read", int'(stat_q[2:0]), 1);
    chk(stat_q[3] == 1'b0, "R6", "reserved bit", int'(stat_q[3]), 0);
    read_status();
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    clear_mem();
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_sweep(2, 8'h40);
    t_sweep(0, 8'h10);
    t_sweep(11, 8'h40);
    t_reserved();
    t_reserved_wrap();
    t_wrap();
    t_stop();
    t_flags();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule